// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the timing reference for a two-output pulse-width modulator. It divides the system clock with two cascaded dividers. One is a power-of-two stage. The other is an even stage that passes the clock through unchanged when its field is zero. On each divided tick, a 16-bit counter moves against a period value. The counter can count up, count down, count up then down, or hold its value.

Downstream compare and output logic uses the following outputs:
- the live count;
- a one-cycle strobe when the count is zero;
- a one-cycle strobe when the count equals the period;
- a direction flag;
- the divided tick itself.

Software reaches the block through a small 16-bit register port with a write strobe, an address and a combinational read. The port holds one control word and one period word. A control bit selects how new period values are applied. They can take effect at once. Or they can wait in a holding copy until the next zero strobe, so that a period change never cuts a cycle short.

Top module: `pwm_timebase`

## Requirements
- R1: After synchronous reset, the count is 0 and `count_down` is 0. The control word reads 0 and the period word reads 0. The prescaler phase is 0, so with the reset dividers `tick_en` is 1.
- R2: The control word sits at address 0x00. Its fields are: mode in bits 1:0, load select in bit 3, even-divider field in bits 9:7, and power-of-two divider field in bits 12:10. Only these bits store, and all other bits read 0. The period word at 0x0A reads back the active period. Any other address reads 0.
- R3: `tick_en` pulses once every 2^C × (F == 0 ? 1 : 2F) clocks, where C is the value in bits 12:10 and F is the value in bits 9:7. The counter changes only on cycles where `tick_en` is 1.
- R4: Mode 00 counts up. On each tick the count rises by one, and a count at or above the period returns to 0. `count_down` is 0 in this mode.
- R5: Mode 01 counts down. On a tick a count of 0 reloads the period, and any other count falls by one. `count_down` is 1 in this mode.
- R6: Mode 10 counts up to the period, then down to 0, and repeats. `count_down` is 1 from the tick after the period match through the tick on which 0 is reached, and 0 otherwise.
- R7: Mode 11 holds the count unchanged and raises neither strobe.
- R8: `zero_hit` is 1 exactly on tick cycles where the count is 0 and the mode is not 11. `period_hit` is 1 exactly on tick cycles where the count equals the active period and the mode is not 11. Neither strobe is ever 1 on a cycle without a tick.
- R9: With bit 3 = 1, a period write becomes the active period on the next clock and is visible at 0x0A.
- R10: With bit 3 = 0, a period write goes only to the holding copy. The holding copy is moved into the active period on the clock that ends a `zero_hit` cycle.
- R11: The full 16-bit period range is usable. A period of 0xFFFF reloads and counts down from 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| tick_en | output | 1 | Divided tick, one clock wide |
| tb_count | output | 16 | Current counter value |
| zero_hit | output | 1 | Count-is-zero strobe |
| period_hit | output | 1 | Count-equals-period strobe |
| count_down | output | 1 | 1 while the counter is moving downward |

## Verification
The bench targets the edges of each counting mode:
- The up-down turnaround: a design that flips the direction flag one tick early or late would show a wrong flag at the period or at zero.
- The reload from zero in down mode with a period of 0xFFFF: a truncated period would reload a smaller value.
- A period of 0 in up mode: a design that compares with "greater than" instead of "at or above" would run away from 0.
- The held period update: the old period must still govern the first zero-to-one step, and the new period must appear only after the zero strobe. A design that loads immediately would produce a different period strobe position.

Each divider combination is timed on a settled tick interval, so that a swapped or mis-scaled divider stage shows up as a wrong gap. In hold mode the count is watched for drift and for stray strobes.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  typedef enum logic [1:0] {
    MODE_UP   = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_UPDN = 2'b10,
    MODE_HOLD = 2'b11
  } tb_mode_e;

  // Control word field positions (decoded by software)
  localparam int CTL_MODE_LSB   = 0;
  localparam int CTL_LOAD_BIT   = 3;
  localparam int CTL_FINE_LSB   = 7;
  localparam int CTL_COARSE_LSB = 10;
  localparam int DIV_FIELD_W    = 3;

  // Total prescale = 2^coarse * (fine == 0 ? 1 : 2*fine)
  function automatic int unsigned presc_total(input logic [DIV_FIELD_W-1:0] coarse,
                                              input logic [DIV_FIELD_W-1:0] fine);
    int unsigned even_stage;
    even_stage = (fine == '0) ? 1 : 2 * int'(fine);
    return (32'd1 << coarse) * even_stage;
  endfunction

endpackage

// File: rtl/tb_prescaler.sv
module tb_prescaler import pwm_tb_pkg::*; #(
  parameter int PS_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DIV_FIELD_W-1:0] coarse,
  input  logic [DIV_FIELD_W-1:0] fine,
  output logic                   tick,
  output logic [PS_W-1:0]        phase
);

  logic [PS_W-1:0] total;

  assign total = PS_W'(presc_total(coarse, fine));
  // >= guards against a divider shrinking below the running phase
  assign tick  = (phase >= total - PS_W'(1));

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + PS_W'(1);
  end

  // R3: between ticks the phase advances by exactly one
  a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
    !tick |=> (phase == PS_W'($past(phase) + PS_W'(1))));

endmodule

// File: rtl/tb_period_reg.sv
module tb_period_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             imm,
  input  logic             load_evt,
  output logic [CNT_W-1:0] active,
  output logic [CNT_W-1:0] shadow
);

  logic take_now;
  logic take_held;

  assign take_now  = wr && imm;
  assign take_held = load_evt && !imm;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
      shadow <= '0;
    end else begin
      if (wr)             shadow <= wdata;
      if (take_now)       active <= wdata;
      else if (take_held) active <= shadow;
    end
  end

  // R10: without a direct write or zero-event transfer the active value stays
  a_r10_active_hold: assert property (@(posedge clk) disable iff (rst)
    (!take_now && !take_held) |=> $stable(active));

  // R9: a direct write lands in the active period on the next clock
  a_r9_imm_take: assert property (@(posedge clk) disable iff (rst)
    take_now |=> (active == $past(wdata)));

endmodule

// File: rtl/tb_counter.sv
module tb_counter import pwm_tb_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  tb_mode_e         mode,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_dn,
  output logic             zero_hit,
  output logic             prd_hit
);

  logic             dir_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             dir_nxt;
  logic             frozen;

  assign frozen   = (mode == MODE_HOLD);
  assign zero_hit = tick && !frozen && (cnt == '0);
  assign prd_hit  = tick && !frozen && (cnt == prd);
  assign dir_dn   = (mode == MODE_DOWN) ? 1'b1 :
                    (mode == MODE_UP)   ? 1'b0 : dir_q;

  always_comb begin
    cnt_nxt = cnt;
    dir_nxt = dir_q;
    unique case (mode)
      MODE_UP: begin
        cnt_nxt = (cnt >= prd) ? '0 : cnt + CNT_W'(1);
        dir_nxt = 1'b0;
      end
      MODE_DOWN: begin
        cnt_nxt = (cnt == '0) ? prd : cnt - CNT_W'(1);
        dir_nxt = 1'b1;
      end
      MODE_UPDN: begin
        if (prd == '0) begin
          cnt_nxt = '0;
        end else if (!dir_q) begin
          if (cnt >= prd) begin
            cnt_nxt = cnt - CNT_W'(1);
            dir_nxt = 1'b1;
          end else begin
            cnt_nxt = cnt + CNT_W'(1);
          end
        end else begin
          if (cnt == '0) begin
            cnt_nxt = CNT_W'(1);
            dir_nxt = 1'b0;
          end else begin
            cnt_nxt = cnt - CNT_W'(1);
          end
        end
      end
      default: begin
        cnt_nxt = cnt;
        dir_nxt = dir_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      dir_q <= 1'b0;
    end else if (tick) begin
      cnt   <= cnt_nxt;
      dir_q <= dir_nxt;
    end
  end

  // R7: hold mode keeps the count
  a_r7_hold_count: assert property (@(posedge clk) disable iff (rst)
    frozen |=> (cnt == $past(cnt)));

  // R7: hold mode raises no strobe
  a_r7_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    frozen |-> (!zero_hit && !prd_hit));

  // R3: the count never moves without a tick
  a_r3_no_tick_still: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  // R4: below the period, up mode steps by one per tick
  a_r4_up_step: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == MODE_UP && cnt < prd) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R5: down mode reloads the period from zero
  a_r5_down_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == MODE_DOWN && cnt == '0) |=> (cnt == $past(prd)));

  // R8: strobes only on tick cycles
  a_r8_strobe_on_tick: assert property (@(posedge clk) disable iff (rst)
    (zero_hit || prd_hit) |-> tick);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase import pwm_tb_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5,
  parameter int PS_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              tick_en,
  output logic [CNT_W-1:0]  tb_count,
  output logic              zero_hit,
  output logic              period_hit,
  output logic              count_down
);

  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] PRD_ADDR = ADDR_W'(10);

  tb_mode_e               mode_q;
  logic                   imm_q;
  logic [DIV_FIELD_W-1:0] fine_q;
  logic [DIV_FIELD_W-1:0] coarse_q;
  logic                   wr_ctl;
  logic                   wr_prd;
  logic [CNT_W-1:0]       prd_act;
  logic [CNT_W-1:0]       prd_held;
  logic [PS_W-1:0]        ps_phase;
  logic [CNT_W-1:0]       ctl_img;

  assign wr_ctl = reg_wr && (reg_addr == CTL_ADDR);
  assign wr_prd = reg_wr && (reg_addr == PRD_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_UP;
      imm_q    <= 1'b0;
      fine_q   <= '0;
      coarse_q <= '0;
    end else if (wr_ctl) begin
      mode_q   <= tb_mode_e'(reg_wdata[CTL_MODE_LSB +: 2]);
      imm_q    <= reg_wdata[CTL_LOAD_BIT];
      fine_q   <= reg_wdata[CTL_FINE_LSB +: DIV_FIELD_W];
      coarse_q <= reg_wdata[CTL_COARSE_LSB +: DIV_FIELD_W];
    end
  end

  always_comb begin
    ctl_img = '0;
    ctl_img[CTL_MODE_LSB +: 2]             = mode_q;
    ctl_img[CTL_LOAD_BIT]                  = imm_q;
    ctl_img[CTL_FINE_LSB +: DIV_FIELD_W]   = fine_q;
    ctl_img[CTL_COARSE_LSB +: DIV_FIELD_W] = coarse_q;
  end

  always_comb begin
    if (reg_addr == CTL_ADDR)      reg_rdata = ctl_img;
    else if (reg_addr == PRD_ADDR) reg_rdata = prd_act;
    else                           reg_rdata = '0;
  end

  tb_prescaler #(.PS_W(PS_W)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .coarse (coarse_q),
    .fine   (fine_q),
    .tick   (tick_en),
    .phase  (ps_phase)
  );

  tb_period_reg #(.CNT_W(CNT_W)) u_prd (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr_prd),
    .wdata    (reg_wdata),
    .imm      (imm_q),
    .load_evt (zero_hit),
    .active   (prd_act),
    .shadow   (prd_held)
  );

  tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_en),
    .mode     (mode_q),
    .prd      (prd_act),
    .cnt      (tb_count),
    .dir_dn   (count_down),
    .zero_hit (zero_hit),
    .prd_hit  (period_hit)
  );

  // R1: the prescaler phase restarts at zero after reset
  a_r1_phase_clear: assert property (@(posedge clk)
    rst |=> (ps_phase == '0));

  // R10: held mode moves the holding copy into the active period on a zero strobe
  a_r10_transfer: assert property (@(posedge clk) disable iff (rst)
    (zero_hit && !imm_q && !wr_prd) |=> (prd_act == $past(prd_held)));

endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int cnt;
    bit z;
    bit p;
    bit d;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tick_en;
  logic [15:0] tb_count;
  logic        zero_hit;
  logic        period_hit;
  logic        count_down;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    mon_on = 1'b0;
  bit    finished = 1'b0;
  string cur_tag = "R1";
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timebase u_pwm_timebase (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .tick_en    (tick_en),
    .tb_count   (tb_count),
    .zero_hit   (zero_hit),
    .period_hit (period_hit),
    .count_down (count_down)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per tick and compares
  always @(negedge clk) begin
    if (mon_on) begin
      if (tick_en && exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        check({cur_tag, " count"}, int'(tb_count), e.cnt);
        check({cur_tag, " R8 zero_hit"}, int'(zero_hit), int'(e.z));
        check({cur_tag, " R8 period_hit"}, int'(period_hit), int'(e.p));
        check({cur_tag, " dir"}, int'(count_down), int'(e.d));
      end else if (!tick_en) begin
        check("R8 strobe without tick", int'(zero_hit | period_hit), 0);
      end
    end
  end

  function automatic int ctlw(input int mode, input bit imm, input int c, input int f);
    return mode | (int'(imm) << 3) | (f << 7) | (c << 10);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int addr, input int data, input bit arm);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(addr); reg_wdata = 16'(data);
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
    if (arm) mon_on = 1'b1;
  endtask

  task automatic rd(input int addr, output int val);
    @(negedge clk);
    reg_addr = 5'(addr);
    #1;
    val = int'(reg_rdata);
  endtask

  // Expected per-tick items from the mode rules, starting at count 0 going up
  task automatic push_run(input int mode, input int p0, input int p1,
                          input bit held, input int n);
    int  c = 0;
    bit  dn = 1'b0;
    int  act = p0;
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.cnt = c;
      it.z = (c == 0);
      it.p = (c == act);
      it.d = (mode == 1) ? 1'b1 : (mode == 0) ? 1'b0 : dn;
      exp_q.push_back(it);
      if (mode == 0) begin
        c = (c >= act) ? 0 : c + 1;
      end else if (mode == 1) begin
        c = (c == 0) ? act : c - 1;
      end else begin
        if (act == 0) c = 0;
        else if (!dn) begin
          if (c >= act) begin dn = 1'b1; c = c - 1; end
          else c = c + 1;
        end else begin
          if (c == 0) begin dn = 1'b0; c = 1; end
          else c = c - 1;
        end
      end
      if (it.z && held) act = p1;
    end
  endtask

  task automatic start_run(input int mode, input bit held, input int c, input int f,
                           input int p0, input int p1, input int n, input string tag);
    int v;
    do_reset();
    cur_tag = tag;
    wr(0, ctlw(3, 1'b1, c, f), 1'b0);
    wr(10, p0, 1'b0);
    rd(10, v);
    check("R9 direct period write visible", v, p0);
    if (held) begin
      wr(0, ctlw(3, 1'b0, c, f), 1'b0);
      wr(10, p1, 1'b0);
      rd(10, v);
      check("R10 held write not yet active", v, p0);
    end
    push_run(mode, p0, p1, held, n);
    wr(0, ctlw(mode, !held, c, f), 1'b1);
    while (exp_q.size() != 0) @(posedge clk);
    #1 mon_on = 1'b0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick_en);
  endtask

  task automatic gap_chk(input int c, input int f);
    int exp_gap;
    int n;
    int even;
    even = 1;
    if (f != 0) even = f + f;
    exp_gap = even;
    for (int k = 0; k < c; k++) exp_gap = exp_gap * 2;
    wr(0, ctlw(0, 1'b1, c, f), 1'b0);
    wait_tick();
    wait_tick();
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_en);
    check($sformatf("R3 tick gap c=%0d f=%0d", c, f), n, exp_gap);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    // R1 reset state
    do_reset();
    check("R1 count after reset", int'(tb_count), 0);
    check("R1 count_down after reset", int'(count_down), 0);
    check("R1 tick_en with phase 0", int'(tick_en), 1);
    rd(0, v);  check("R1 control reads 0", v, 0);
    rd(10, v); check("R1 period reads 0", v, 0);

    // R2 register map
    wr(0, 16'hFFFF, 1'b0);
    rd(0, v);  check("R2 control stored bits", v, 16'h1F8B);
    rd(4, v);  check("R2 unmapped address reads 0", v, 0);
    wr(0, 0, 1'b0);
    rd(0, v);  check("R2 control cleared", v, 0);

    // R3 divider combinations
    gap_chk(0, 0);
    gap_chk(2, 0);
    gap_chk(0, 3);
    gap_chk(1, 2);
    gap_chk(3, 5);

    // R4 up mode, R8 strobes
    start_run(0, 1'b0, 0, 0, 4, 4, 12, "R4 up P=4");
    start_run(0, 1'b0, 1, 0, 0, 0, 4, "R4 up P=0");
    // R5 down mode
    start_run(1, 1'b0, 1, 0, 3, 3, 10, "R5 down P=3");
    // R11 full-range period
    start_run(1, 1'b0, 0, 0, 16'hFFFF, 16'hFFFF, 5, "R11 down P=FFFF");
    // R6 up-down
    start_run(2, 1'b0, 0, 1, 3, 3, 15, "R6 updown P=3");
    // R10 held period update
    start_run(0, 1'b1, 0, 0, 3, 7, 13, "R10 held 3->7");
    rd(10, v); check("R10 held value became active", v, 7);

    // R7 hold mode
    begin
      int  c0;
      bit  bad;
      start_run(0, 1'b0, 0, 0, 9, 9, 0, "R7 prep");
      repeat (7) @(negedge clk);
      wr(0, ctlw(3, 1'b1, 0, 0), 1'b0);
      @(negedge clk);
      c0 = int'(tb_count);
      bad = 1'b0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (int'(tb_count) != c0 || zero_hit || period_hit) bad = 1'b1;
      end
      check("R7 hold keeps count, no strobes", int'(bad), 0);
      check("R7 held count value", int'(tb_count), c0);
      // R9 direct write while holding
      wr(10, 5, 1'b0);
      rd(10, v); check("R9 direct write next clock", v, 5);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule